// File: doc/BRIEF.md
# Address-Decoded Port Resource Selector

This block is the controlling-side front end of an 18-bit bidirectional data port. On every rising clock edge it looks at chip select, a 3-bit address, the read/write line and the transfer enable. From these it decides which of several internal resources the transfer belongs to: the outbound FIFO (write), the inbound FIFO (read), the bypass channel in either direction, or one of four flag-offset registers that set the almost-empty and almost-full thresholds of both FIFOs.

The block holds the four offset registers and presents them as steady outputs to the flag logic. It owns the port's output register, which captures inbound FIFO data, bypass data or an offset value on a read. It also produces the data-bus drive enable and enforces a one-cycle bus turnaround rule. The FIFO arrays and the bypass mailbox sit outside. They receive one-cycle strobes and the write word, and they return their read words. A registered bypass-mode signal tells the far port whether its reads come from the FIFO or from the bypass channel.

Top module: `port_res_sel`

## Requirements
- R1: While `cs_n` is HIGH, no transfer strobe fires, `bus_oe` is LOW, and writes do not change the offset registers.
- R2: With `cs_n` LOW, `en_n` LOW and address 000, a write (`rw`=0) pulses `ab_fifo_wr` with `wdata` equal to `din`. A read (`rw`=1) pulses `ba_fifo_rd`, and after that edge `dout` equals `ba_fifo_data`.
- R3: Address 001 routes a write to `byp_wr` and a read to `byp_rd`, and the read loads `byp_data` into `dout`. `byp_mode` is HIGH one edge after a clock on which `cs_n` is LOW with address 001. It is LOW one edge after any other address (including 000 and 1xx) or `cs_n` HIGH.
- R4: A write to address 100, 101, 110 or 111 stores `din` bits [log2(DEPTH)-1:0] (9 bits by default) into, respectively, the outbound almost-empty, outbound almost-full, inbound almost-empty or inbound almost-full offset. Upper data bits are ignored, and the new value is on the offset output after that same edge.
- R5: A read at address 1xx loads the selected offset, zero-extended, into `dout`, and fires no FIFO or bypass strobe.
- R6: With `en_n` HIGH no strobe fires, `dout` holds its value and the offsets hold.
- R7: A clock edge with `rst_n`, `cs_n`, `en_n` and `enb_n` sampled as LOW, HIGH, HIGH and HIGH sets all four offsets to 8, `dout` to 0 and `byp_mode` to 0. With `rst_n` LOW but any of the other three LOW, the block operates normally and nothing is reset.
- R8: `bus_oe` is HIGH exactly when `cs_n` is LOW, `rw` is HIGH and `oe_n` is LOW, in the same cycle and without a register.
- R9: A write on the edge right after an edge at which `bus_oe` was HIGH is ignored: no write strobe fires and no offset changes. A write one cycle later is accepted.
- R10: Addresses 010 and 011 select nothing: no strobe fires, `dout` holds, and the offsets hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Reset request, active LOW, qualified by the idle controls |
| cs_n | input | 1 | Chip select, active LOW |
| addr | input | 3 | Resource address |
| rw | input | 1 | 1 = read, 0 = write |
| en_n | input | 1 | Transfer enable, active LOW |
| oe_n | input | 1 | Output enable, active LOW |
| enb_n | input | 1 | Far-port transfer enable, used only to qualify reset |
| din | input | 18 | Word from the data bus |
| ba_fifo_data | input | 18 | Head word of the inbound FIFO |
| byp_data | input | 18 | Word waiting in the inbound bypass channel |
| wdata | output | 18 | Write word to the outbound FIFO or bypass channel |
| ab_fifo_wr | output | 1 | Outbound FIFO write strobe |
| ba_fifo_rd | output | 1 | Inbound FIFO read strobe |
| byp_wr | output | 1 | Outbound bypass write strobe |
| byp_rd | output | 1 | Inbound bypass read strobe |
| dout | output | 18 | Port output register |
| bus_oe | output | 1 | Data-bus drive enable |
| byp_mode | output | 1 | Bypass mode seen by the far port |
| ofs_ae_ab | output | 9 | Outbound almost-empty offset |
| ofs_af_ab | output | 9 | Outbound almost-full offset |
| ofs_ae_ba | output | 9 | Inbound almost-empty offset |
| ofs_af_ba | output | 9 | Inbound almost-full offset |

## Verification
Directed sequences come first. Offset writes whose data words carry junk in the upper bits, followed by read-back, separate correct field masking from plain pass-through, and they show that each address reaches its own register. Back-to-back read-then-write pairs with output enable LOW and HIGH tell the turnaround block apart from a write that is simply lost. Held-enable, deselected and reserved-address cycles show that nothing moves when nothing is selected. Reset is requested with each qualifying control LOW in turn. A long pseudo-random run then mixes every address, direction and enable pattern, and it is compared on every clock against a behavioural model of the output register, the offsets and the strobes.

// File: rtl/port_res_sel.sv
`timescale 1ns/1ps
module port_res_sel #(
  parameter int DW       = 18,
  parameter int DEPTH    = 512,
  parameter int OFS_INIT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic [2:0]                 addr,
  input  logic                       rw,
  input  logic                       en_n,
  input  logic                       oe_n,
  input  logic                       enb_n,
  input  logic [DW-1:0]              din,
  input  logic [DW-1:0]              ba_fifo_data,
  input  logic [DW-1:0]              byp_data,
  output logic [DW-1:0]              wdata,
  output logic                       ab_fifo_wr,
  output logic                       ba_fifo_rd,
  output logic                       byp_wr,
  output logic                       byp_rd,
  output logic [DW-1:0]              dout,
  output logic                       bus_oe,
  output logic                       byp_mode,
  output logic [$clog2(DEPTH)-1:0]   ofs_ae_ab,
  output logic [$clog2(DEPTH)-1:0]   ofs_af_ab,
  output logic [$clog2(DEPTH)-1:0]   ofs_ae_ba,
  output logic [$clog2(DEPTH)-1:0]   ofs_af_ba
);
  localparam int OW = $clog2(DEPTH);
  localparam logic [OW-1:0] OFS_RST = OW'(OFS_INIT);

  logic [OW-1:0] ofs_q [4];
  logic [DW-1:0] dout_q, rd_word;
  logic          drove_q, byp_q;
  logic          act, wr_ok, rd_ok, rst_ok;

  assign act    = !cs_n && !en_n;
  assign wr_ok  = act && !rw && !drove_q;
  assign rd_ok  = act && rw;
  assign rst_ok = !rst_n && cs_n && en_n && enb_n;

  assign wdata      = din;
  assign ab_fifo_wr = wr_ok && (addr == 3'b000);
  assign byp_wr     = wr_ok && (addr == 3'b001);
  assign ba_fifo_rd = rd_ok && (addr == 3'b000);
  assign byp_rd     = rd_ok && (addr == 3'b001);
  assign bus_oe     = !cs_n && rw && !oe_n;

  always_comb begin
    if (addr[2])
      rd_word = {{(DW-OW){1'b0}}, ofs_q[addr[1:0]]};
    else if (addr[1])
      rd_word = dout_q;
    else if (addr[0])
      rd_word = byp_data;
    else
      rd_word = ba_fifo_data;
  end

  always_ff @(posedge clk) begin
    if (rst_ok) begin
      dout_q  <= '0;
      drove_q <= 1'b0;
      byp_q   <= 1'b0;
      for (int i = 0; i < 4; i++) ofs_q[i] <= OFS_RST;
    end else begin
      if (rd_ok) dout_q <= rd_word;
      drove_q <= bus_oe;
      byp_q   <= !cs_n && (addr == 3'b001);
      for (int i = 0; i < 4; i++)
        if (wr_ok && addr[2] && (addr[1:0] == 2'(i))) ofs_q[i] <= din[OW-1:0];
    end
  end

  assign dout      = dout_q;
  assign byp_mode  = byp_q;
  assign ofs_ae_ab = ofs_q[0];
  assign ofs_af_ab = ofs_q[1];
  assign ofs_ae_ba = ofs_q[2];
  assign ofs_af_ba = ofs_q[3];

  assert_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(ab_fifo_wr || byp_wr || ba_fifo_rd || byp_rd || bus_oe));

  assert_cs_no_byp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !byp_mode);

  assert_ofs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && !en_n && !rw && addr[2]) |=>
      $stable({ofs_ae_ab, ofs_af_ab, ofs_ae_ba, ofs_af_ba}));

  assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !en_n && rw && addr == 3'b110) |=> (dout == {{(DW-OW){1'b0}}, ofs_ae_ba}));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || en_n) |=> $stable(dout));

  assert_oe_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> !bus_oe);

  assert_turnaround_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> !(ab_fifo_wr || byp_wr));

  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[2:1] == 2'b01) |-> !(ab_fifo_wr || byp_wr || ba_fifo_rd || byp_rd));
endmodule

// File: tb/sim_port_res_sel.sv
`timescale 1ns/1ps
module sim_port_res_sel;
  logic clk = 1'b0;
  logic rst_n, cs_n, rw, en_n, oe_n, enb_n;
  logic [2:0]  addr;
  logic [17:0] din, ba_fifo_data, byp_data, wdata, dout;
  logic ab_fifo_wr, ba_fifo_rd, byp_wr, byp_rd, bus_oe, byp_mode;
  logic [8:0] ofs_ae_ab, ofs_af_ab, ofs_ae_ba, ofs_af_ba;

  int checks = 0, failures = 0, ncyc = 0;
  bit done = 0;
  int m_ofs [4];
  int m_dout, m_drove, m_byp;
  int unsigned lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  port_res_sel u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rw(rw),
    .en_n(en_n), .oe_n(oe_n), .enb_n(enb_n), .din(din), .ba_fifo_data(ba_fifo_data),
    .byp_data(byp_data), .wdata(wdata), .ab_fifo_wr(ab_fifo_wr), .ba_fifo_rd(ba_fifo_rd),
    .byp_wr(byp_wr), .byp_rd(byp_rd), .dout(dout), .bus_oe(bus_oe), .byp_mode(byp_mode),
    .ofs_ae_ab(ofs_ae_ab), .ofs_af_ab(ofs_af_ab), .ofs_ae_ba(ofs_ae_ba), .ofs_af_ba(ofs_af_ba));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit r, input bit c, input bit [2:0] a,
                     input bit w, input bit e, input bit o, input bit eb, input bit [17:0] d);
    bit act, wr, rd;
    rst_n = r; cs_n = c; addr = a; rw = w; en_n = e; oe_n = o; enb_n = eb; din = d;
    ba_fifo_data = 18'h10000 + 18'(ncyc);
    byp_data     = 18'h20000 + 18'(3 * ncyc);
    ncyc++;
    #1;
    act = !c && !e;
    wr  = act && !w && (m_drove == 0);
    rd  = act && w;
    chk(tag, "ab_fifo_wr", int'(ab_fifo_wr), int'(wr && a == 3'b000));
    chk(tag, "byp_wr",     int'(byp_wr),     int'(wr && a == 3'b001));
    chk(tag, "ba_fifo_rd", int'(ba_fifo_rd), int'(rd && a == 3'b000));
    chk(tag, "byp_rd",     int'(byp_rd),     int'(rd && a == 3'b001));
    chk(tag, "bus_oe",     int'(bus_oe),     int'(!c && w && !o));
    if (wr && a == 3'b000) chk(tag, "wdata", int'(wdata), int'(d));
    @(posedge clk);
    if (!r && c && e && eb) begin
      foreach (m_ofs[i]) m_ofs[i] = 8;
      m_dout = 0; m_drove = 0; m_byp = 0;
    end else begin
      if (wr && a[2]) m_ofs[a[1:0]] = int'(d) & 511;
      if (rd) begin
        if (a == 3'b000) m_dout = int'(ba_fifo_data);
        else if (a == 3'b001) m_dout = int'(byp_data);
        else if (a[2]) m_dout = m_ofs[a[1:0]];
      end
      m_byp   = (!c && a == 3'b001) ? 1 : 0;
      m_drove = (!c && w && !o) ? 1 : 0;
    end
    @(negedge clk);
    chk(tag, "dout",     int'(dout),     m_dout);
    chk(tag, "byp_mode", int'(byp_mode), m_byp);
    chk(tag, "ofs_ae_ab", int'(ofs_ae_ab), m_ofs[0]);
    chk(tag, "ofs_af_ab", int'(ofs_af_ab), m_ofs[1]);
    chk(tag, "ofs_ae_ba", int'(ofs_ae_ba), m_ofs[2]);
    chk(tag, "ofs_af_ba", int'(ofs_af_ba), m_ofs[3]);
  endtask

  initial begin
    #(50000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    foreach (m_ofs[i]) m_ofs[i] = 0;
    m_dout = 0; m_drove = 0; m_byp = 0;
    rst_n = 0; cs_n = 1; en_n = 1; enb_n = 1; rw = 1; oe_n = 1; addr = 0; din = 0;
    ba_fifo_data = 0; byp_data = 0;
    @(negedge clk);
    cyc("R7", 0, 1, 3'b000, 1, 1, 1, 1, 18'h0);
    cyc("R7", 0, 1, 3'b000, 1, 1, 1, 1, 18'h0);
    // offset writes with upper junk, then read-back
    cyc("R4", 1, 0, 3'b100, 0, 0, 1, 1, 18'h3FE05);
    cyc("R4", 1, 0, 3'b101, 0, 0, 1, 1, 18'h001FF);
    cyc("R4", 1, 0, 3'b110, 0, 0, 1, 1, 18'h2AB0C);
    cyc("R4", 1, 0, 3'b111, 0, 0, 1, 1, 18'h3FF00);
    for (int k = 4; k < 8; k++) cyc("R5", 1, 0, 3'(k), 1, 0, 1, 1, 18'h0);
    // FIFO traffic
    for (int k = 0; k < 3; k++) cyc("R2", 1, 0, 3'b000, 0, 0, 1, 1, 18'(18'h0ABC0 + k));
    for (int k = 0; k < 3; k++) cyc("R2", 1, 0, 3'b000, 1, 0, 1, 1, 18'h0);
    // driven read then write: blocked; next write accepted
    cyc("R8", 1, 0, 3'b000, 1, 0, 0, 1, 18'h0);
    cyc("R9", 1, 0, 3'b000, 0, 0, 0, 1, 18'h15555);
    cyc("R9", 1, 0, 3'b000, 0, 0, 0, 1, 18'h15556);
    cyc("R8", 1, 0, 3'b101, 1, 1, 0, 1, 18'h0);
    cyc("R9", 1, 0, 3'b101, 0, 0, 1, 1, 18'h00077);
    cyc("R9", 1, 0, 3'b101, 0, 0, 1, 1, 18'h00033);
    // enable held HIGH
    cyc("R6", 1, 0, 3'b000, 1, 1, 1, 1, 18'h0);
    cyc("R6", 1, 0, 3'b110, 0, 1, 1, 1, 18'h00011);
    cyc("R6", 1, 0, 3'b001, 1, 1, 0, 1, 18'h0);
    // deselected
    cyc("R1", 1, 1, 3'b100, 0, 0, 0, 1, 18'h00099);
    cyc("R1", 1, 1, 3'b000, 1, 0, 0, 1, 18'h0);
    // reserved addresses
    cyc("R10", 1, 0, 3'b010, 1, 0, 1, 1, 18'h0);
    cyc("R10", 1, 0, 3'b011, 0, 0, 1, 1, 18'h00044);
    cyc("R10", 1, 0, 3'b010, 0, 0, 1, 1, 18'h00045);
    // bypass entry, traffic, exit
    cyc("R3", 1, 0, 3'b001, 0, 0, 1, 1, 18'h2BEEF);
    cyc("R3", 1, 0, 3'b001, 1, 0, 1, 1, 18'h0);
    cyc("R3", 1, 0, 3'b001, 1, 1, 1, 1, 18'h0);
    cyc("R3", 1, 0, 3'b100, 1, 1, 1, 1, 18'h0);
    cyc("R3", 1, 0, 3'b001, 1, 1, 1, 1, 18'h0);
    cyc("R3", 1, 1, 3'b001, 1, 1, 1, 1, 18'h0);
    cyc("R3", 1, 0, 3'b001, 1, 1, 1, 1, 18'h0);
    cyc("R3", 1, 0, 3'b000, 1, 1, 1, 1, 18'h0);
    // unqualified reset requests do nothing
    cyc("R7", 0, 0, 3'b111, 0, 0, 1, 1, 18'h00123);
    cyc("R7", 0, 1, 3'b000, 1, 0, 1, 1, 18'h0);
    cyc("R7", 0, 1, 3'b000, 1, 1, 1, 0, 18'h0);
    cyc("R7", 0, 1, 3'b000, 1, 1, 1, 1, 18'h0);
    cyc("R5", 1, 0, 3'b111, 1, 0, 1, 1, 18'h0);
    // pseudo-random mix
    for (int k = 0; k < 400; k++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      cyc("R2", 1, lfsr[0] & lfsr[1], lfsr[4:2], lfsr[5], lfsr[6] & lfsr[7],
          lfsr[8], 1, lfsr[26:9]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule